// File: doc/BRIEF.md
# Calendar Clock Access Sequencer

This block runs complete transactions against a serial timekeeping peripheral. In that peripheral every time field is split into a units nibble register and a tens nibble register. One register-level master sits below the block and carries single nibble reads and writes. The sequencer drives the peripheral's chip enable and issues one register request at a time over a req/done handshake. It assembles or splits the packed BCD bytes for seconds, minutes, hours, day, month and year, plus a 4-bit weekday.

The host has three commands: a full time read, a full time write and a start-up integrity check. A read or write always opens with a busy handshake on the control register. While the peripheral reports an adjustment in progress, the block drops chip enable, waits out a minimum gap and probes again. If the busy flag never clears, it gives up with an error. The integrity check looks for a stop flag left by a loss of oscillation. When that flag is set, the block runs an adjust sequence, loads a default date and records the event in a sticky flag.

Top module: `cal_access_seq`

## Requirements
- R1: After reset, ce_o, req_o, busy_o, done_o, err_o and recov_o are all 0.
- R2: A read or write command raises ce_o with a write of 0x4 to the control register (address 0xE), followed by a read of address 0xE. When bit 0 (busy) of that read is 0, the field transfers start without a further probe.
- R3: When bit 0 of a probe read is 1, ce_o goes low for at least GAP_CYC cycles (default 140, which is 700 ns at 200 MHz) and the probe pair is repeated. Every low period of ce_o between two high periods lasts at least GAP_CYC cycles.
- R4: The block allows up to MAX_RETRY retries (default 101). If the probe after the last allowed retry still reads busy, the command ends with err_o = 1, with no field transfer and with the read outputs unchanged. 101 busy probes followed by a clear one complete normally. err_o clears when the next command is accepted.
- R5: A read fetches addresses 0,1 (seconds), 2,3 (minutes), 4,5 (hours), 8,9 (day), A,B (month), C,D (year), units before tens, and then address 6 (weekday). Each byte output is the tens nibble in bits 7:4 and the units nibble in bits 3:0.
- R6: A write stores the nibbles in the same address order as R5. The data comes from the wr_*_i values sampled in the cycle the command is accepted, and later changes on those inputs have no effect.
- R7: At the end of a command ce_o is low for GAP_CYC cycles before done_o pulses for exactly one cycle. busy_o is 1 from the cycle after acceptance up to the done cycle, and 0 in the done cycle.
- R8: A check command reads address 0xE once with no probe. If bit 1 (stop) is 0, the command ends with no other request, and recov_o keeps its value.
- R9: If the stop bit is 1, the check writes 0x0 to address 7 and then 0x7 to address 0xE. It then reads 0xE until bit 0 is 0 or POLL_MAX (100) reads have been made. Next it runs the R2/R3 probe and writes 00:00:00, day 01, month 01, year 00, weekday 0 in the R5 order.
- R10: recov_o is set by a check that finds the stop bit, stays set, and is cleared only by recov_clr_i.
- R11: A command that arrives while busy_o is 1 is ignored. When several commands arrive together, read wins over write, and write wins over check.
- R12: req_o, req_we_o, req_addr_o and req_wdata_o stay stable from the cycle a request is raised until req_done_i. req_wdata_o is 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_read_i | input | 1 | Start full time read |
| start_write_i | input | 1 | Start full time write |
| start_check_i | input | 1 | Start power-loss integrity check |
| recov_clr_i | input | 1 | Clear the recovery flag |
| wr_sec_i | input | 8 | Seconds to write, BCD |
| wr_min_i | input | 8 | Minutes to write, BCD |
| wr_hour_i | input | 8 | Hours to write, BCD |
| wr_day_i | input | 8 | Day to write, BCD |
| wr_mon_i | input | 8 | Month to write, BCD |
| wr_year_i | input | 8 | Year to write, BCD |
| wr_wday_i | input | 4 | Weekday to write |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last command timed out on busy |
| recov_o | output | 1 | Sticky: default date was loaded |
| rd_sec_o | output | 8 | Seconds read, BCD |
| rd_min_o | output | 8 | Minutes read, BCD |
| rd_hour_o | output | 8 | Hours read, BCD |
| rd_day_o | output | 8 | Day read, BCD |
| rd_mon_o | output | 8 | Month read, BCD |
| rd_year_o | output | 8 | Year read, BCD |
| rd_wday_o | output | 4 | Weekday read |
| ce_o | output | 1 | Peripheral chip enable |
| req_o | output | 1 | Register request valid |
| req_we_o | output | 1 | Request is a write |
| req_addr_o | output | 4 | Register address |
| req_wdata_o | output | 4 | Nibble to write |
| req_done_i | input | 1 | Request completed (one cycle) |
| req_rdata_i | input | 4 | Nibble read, valid with req_done_i |

## Verification
The bench aims at the retry boundary from both sides: 101 busy probes must still succeed, while 102 must abort. A retry counter that is off by one either fails a legal access or makes one probe too many. Both show up as a mismatch against the expected request list. The power-loss path runs once with a short busy poll and once where the poll limit runs out and probe retries take over. A design that ignored the poll limit would keep reading the control register, and one that skipped the probe after polling would write the default date too early. A command pulsed during an access, changed write inputs after acceptance and a three-way simultaneous start all target the acceptance logic. Wrong handling there produces extra or reordered register traffic, or the wrong nibbles on the write path.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned NUM_STEPS  = 2 * NUM_FIELDS + 1;
  localparam int unsigned STEP_W     = $clog2(NUM_STEPS);

  localparam logic [3:0] ADDR_CTRL  = 4'hE;
  localparam logic [3:0] ADDR_INTV  = 4'h7;
  localparam logic [3:0] ADDR_WDAY  = 4'h6;
  localparam logic [3:0] CTRL_PROBE = 4'h4;
  localparam logic [3:0] CTRL_ADJ   = 4'h7;
  localparam logic [3:0] INTV_OFF   = 4'h0;
  localparam int unsigned BUSY_BIT  = 0;
  localparam int unsigned STOP_BIT  = 1;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
    logic [3:0] wday;
  } cal_time_t;

  localparam cal_time_t DEFAULT_TIME = '{year: 8'h00, mon: 8'h01, day: 8'h01,
                                         hour: 8'h00, min: 8'h00, sec: 8'h00,
                                         wday: 4'h0};

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_CLR_INT, S_SET_ADJ, S_POLL,
    S_PRB_W, S_PRB_R, S_XFER, S_GAP
  } seq_state_e;
endpackage

// File: rtl/cal_step_map.sv
`timescale 1ns/1ps
module cal_step_map
  import cal_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output logic [3:0]        addr_o,
  output logic [2:0]        field_o,
  output logic              tens_o
);
  logic [3:0] base;

  always_comb begin
    field_o = step_i[3:1];
    tens_o  = step_i[0];
    unique case (step_i[3:1])
      3'd0:    base = 4'h0;
      3'd1:    base = 4'h2;
      3'd2:    base = 4'h4;
      3'd3:    base = 4'h8;
      3'd4:    base = 4'hA;
      3'd5:    base = 4'hC;
      default: base = ADDR_WDAY;
    endcase
    if (step_i == STEP_W'(NUM_STEPS - 1)) begin
      field_o = 3'd6;
      tens_o  = 1'b0;
      addr_o  = ADDR_WDAY;
    end else begin
      addr_o  = base | {3'b000, step_i[0]};
    end
  end
endmodule

// File: rtl/cal_gap_timer.sv
`timescale 1ns/1ps
module cal_gap_timer #(
  parameter int unsigned GAP_CYC = 140
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic zero_o
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(GAP_CYC - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cal_time_store.sv
`timescale 1ns/1ps
module cal_time_store
  import cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  cal_time_t  load_val_i,
  input  logic       cap_i,
  input  logic [2:0] field_i,
  input  logic       tens_i,
  input  logic [3:0] nib_i,
  output logic [3:0] wr_nib_o,
  output cal_time_t  rd_o
);
  logic [7:0] wr_b [NUM_FIELDS];
  logic [3:0] wr_wd_q;
  logic [7:0] rd_bytes [NUM_FIELDS];
  logic [3:0] rd_wd_q;
  logic [7:0] sel_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_FIELDS; i++) wr_b[i] <= '0;
      wr_wd_q <= '0;
    end else if (load_i) begin
      wr_b[0] <= load_val_i.sec;
      wr_b[1] <= load_val_i.min;
      wr_b[2] <= load_val_i.hour;
      wr_b[3] <= load_val_i.day;
      wr_b[4] <= load_val_i.mon;
      wr_b[5] <= load_val_i.year;
      wr_wd_q <= load_val_i.wday;
    end
  end

  always_comb begin
    sel_b = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (field_i == 3'(i)) sel_b = wr_b[i];
    if (field_i == 3'd6) wr_nib_o = wr_wd_q;
    else                 wr_nib_o = tens_i ? sel_b[7:4] : sel_b[3:0];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (cap_i && field_i == 3'(g)) begin
        if (tens_i) byte_q[7:4] <= nib_i;
        else        byte_q[3:0] <= nib_i;
      end
    end
    assign rd_bytes[g] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rd_wd_q <= '0;
    else if (cap_i && field_i == 3'd6)   rd_wd_q <= nib_i;
  end

  assign rd_o = '{year: rd_bytes[5], mon: rd_bytes[4], day: rd_bytes[3],
                  hour: rd_bytes[2], min: rd_bytes[1], sec: rd_bytes[0],
                  wday: rd_wd_q};
endmodule

// File: rtl/cal_access_seq.sv
`timescale 1ns/1ps
module cal_access_seq
  import cal_pkg::*;
#(
  parameter int unsigned GAP_CYC   = 140,
  parameter int unsigned MAX_RETRY = 101,
  parameter int unsigned POLL_MAX  = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_read_i,
  input  logic       start_write_i,
  input  logic       start_check_i,
  input  logic       recov_clr_i,
  input  logic [7:0] wr_sec_i,
  input  logic [7:0] wr_min_i,
  input  logic [7:0] wr_hour_i,
  input  logic [7:0] wr_day_i,
  input  logic [7:0] wr_mon_i,
  input  logic [7:0] wr_year_i,
  input  logic [3:0] wr_wday_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic       recov_o,
  output logic [7:0] rd_sec_o,
  output logic [7:0] rd_min_o,
  output logic [7:0] rd_hour_o,
  output logic [7:0] rd_day_o,
  output logic [7:0] rd_mon_o,
  output logic [7:0] rd_year_o,
  output logic [3:0] rd_wday_o,
  output logic       ce_o,
  output logic       req_o,
  output logic       req_we_o,
  output logic [3:0] req_addr_o,
  output logic [3:0] req_wdata_o,
  input  logic       req_done_i,
  input  logic [3:0] req_rdata_i
);
  localparam int unsigned RW = $clog2(MAX_RETRY + 1);
  localparam int unsigned PW = $clog2(POLL_MAX + 1);
  localparam int unsigned LW = $clog2(GAP_CYC + 1);

  seq_state_e         state_q, state_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [RW-1:0]      retry_q, retry_d;
  logic [PW-1:0]      poll_q, poll_d;
  logic               op_wr_q, op_wr_d;
  logic               fin_q, fin_d;
  logic               err_q, err_d;
  logic               done_q, done_d;
  logic               recov_q, recov_d;
  logic               load_wr, load_def, cap, gap_go, gap_zero;
  logic [3:0]         map_addr, wr_nib;
  logic [2:0]         map_field;
  logic               map_tens;
  logic               any_start;
  cal_time_t          in_time, rd_time;

  assign any_start = start_read_i | start_write_i | start_check_i;
  assign in_time   = '{year: wr_year_i, mon: wr_mon_i, day: wr_day_i, hour: wr_hour_i,
                       min: wr_min_i, sec: wr_sec_i, wday: wr_wday_i};

  cal_step_map i_map (
    .step_i (step_q),
    .addr_o (map_addr),
    .field_o(map_field),
    .tens_o (map_tens)
  );

  cal_gap_timer #(.GAP_CYC(GAP_CYC)) i_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(gap_go),
    .zero_o (gap_zero)
  );

  cal_time_store i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_wr | load_def),
    .load_val_i(load_def ? DEFAULT_TIME : in_time),
    .cap_i     (cap),
    .field_i   (map_field),
    .tens_i    (map_tens),
    .nib_i     (req_rdata_i),
    .wr_nib_o  (wr_nib),
    .rd_o      (rd_time)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    retry_d  = retry_q;
    poll_d   = poll_q;
    op_wr_d  = op_wr_q;
    fin_d    = fin_q;
    err_d    = err_q;
    done_d   = 1'b0;
    recov_d  = recov_q & ~recov_clr_i;
    load_wr  = 1'b0;
    load_def = 1'b0;
    cap      = 1'b0;
    gap_go   = 1'b0;
    unique case (state_q)
      S_IDLE: if (any_start) begin
        err_d   = 1'b0;
        retry_d = '0;
        poll_d  = '0;
        step_d  = '0;
        op_wr_d = ~start_read_i & start_write_i;
        load_wr = ~start_read_i & start_write_i;
        state_d = (start_read_i | start_write_i) ? S_PRB_W : S_CHK;
      end
      S_CHK: if (req_done_i) begin
        if (req_rdata_i[STOP_BIT]) begin
          recov_d  = 1'b1;
          load_def = 1'b1;
          op_wr_d  = 1'b1;
          state_d  = S_CLR_INT;
        end else begin
          fin_d   = 1'b1;
          gap_go  = 1'b1;
          state_d = S_GAP;
        end
      end
      S_CLR_INT: if (req_done_i) state_d = S_SET_ADJ;
      S_SET_ADJ: if (req_done_i) state_d = S_POLL;
      S_POLL: if (req_done_i) begin
        if (!req_rdata_i[BUSY_BIT] || poll_q == PW'(POLL_MAX - 1)) begin
          retry_d = '0;
          state_d = S_PRB_W;
        end else begin
          poll_d = poll_q + 1'b1;
        end
      end
      S_PRB_W: if (req_done_i) state_d = S_PRB_R;
      S_PRB_R: if (req_done_i) begin
        if (!req_rdata_i[BUSY_BIT]) begin
          step_d  = '0;
          state_d = S_XFER;
        end else begin
          gap_go  = 1'b1;
          state_d = S_GAP;
          if (retry_q == RW'(MAX_RETRY)) begin
            err_d = 1'b1;
            fin_d = 1'b1;
          end else begin
            retry_d = retry_q + 1'b1;
            fin_d   = 1'b0;
          end
        end
      end
      S_XFER: if (req_done_i) begin
        cap = ~op_wr_q;
        if (step_q == STEP_W'(NUM_STEPS - 1)) begin
          fin_d   = 1'b1;
          gap_go  = 1'b1;
          state_d = S_GAP;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      S_GAP: if (gap_zero) begin
        if (fin_q) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_PRB_W;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      retry_q <= '0;
      poll_q  <= '0;
      op_wr_q <= 1'b0;
      fin_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      recov_q <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      retry_q <= retry_d;
      poll_q  <= poll_d;
      op_wr_q <= op_wr_d;
      fin_q   <= fin_d;
      err_q   <= err_d;
      done_q  <= done_d;
      recov_q <= recov_d;
    end
  end

  always_comb begin
    req_o       = 1'b1;
    req_we_o    = 1'b0;
    req_addr_o  = ADDR_CTRL;
    req_wdata_o = '0;
    unique case (state_q)
      S_CHK, S_POLL, S_PRB_R: ;
      S_CLR_INT: begin req_we_o = 1'b1; req_addr_o = ADDR_INTV; req_wdata_o = INTV_OFF;   end
      S_SET_ADJ: begin req_we_o = 1'b1; req_wdata_o = CTRL_ADJ;   end
      S_PRB_W:   begin req_we_o = 1'b1; req_wdata_o = CTRL_PROBE; end
      S_XFER: begin
        req_we_o    = op_wr_q;
        req_addr_o  = map_addr;
        req_wdata_o = op_wr_q ? wr_nib : 4'h0;
      end
      default: req_o = 1'b0;
    endcase
  end

  assign busy_o    = (state_q != S_IDLE);
  assign ce_o      = (state_q != S_IDLE) && (state_q != S_GAP);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign recov_o   = recov_q;
  assign rd_sec_o  = rd_time.sec;
  assign rd_min_o  = rd_time.min;
  assign rd_hour_o = rd_time.hour;
  assign rd_day_o  = rd_time.day;
  assign rd_mon_o  = rd_time.mon;
  assign rd_year_o = rd_time.year;
  assign rd_wday_o = rd_time.wday;

  // checker-side count of chip enable low cycles, saturating
  logic [LW-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            low_run_q <= LW'(GAP_CYC);
    else if (ce_o)                          low_run_q <= '0;
    else if (low_run_q < LW'(GAP_CYC))      low_run_q <= low_run_q + 1'b1;
  end

  // R3
  ce_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_o) |-> low_run_q >= LW'(GAP_CYC));

  // R2
  ce_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_o) |-> req_o && req_addr_o == ADDR_CTRL);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  err_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !ce_o);

  // R10
  recov_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_o && !recov_clr_i |=> recov_o);

  // R12
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !req_done_i |=> req_o && $stable(req_addr_o) && $stable(req_we_o)
                             && $stable(req_wdata_o));
endmodule

// File: tb/test_cal_access_seq.sv
`timescale 1ns/1ps
module test_cal_access_seq;
  localparam int GAP = 140;
  localparam int MAXR = 101;
  localparam int PMAX = 100;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_rd = 0, st_wr = 0, st_ck = 0, rclr = 0;
  logic [7:0] w_sec = 0, w_min = 0, w_hour = 0, w_day = 0, w_mon = 0, w_year = 0;
  logic [3:0] w_wd = 0;
  logic busy, done, err, recov, ce, req, req_we, req_done = 0;
  logic [7:0] r_sec, r_min, r_hour, r_day, r_mon, r_year;
  logic [3:0] r_wd, req_addr, req_wdata, req_rdata = 0;

  always #2.5 clk = ~clk;

  cal_access_seq i_cal_access_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .start_read_i(st_rd), .start_write_i(st_wr), .start_check_i(st_ck),
    .recov_clr_i(rclr),
    .wr_sec_i(w_sec), .wr_min_i(w_min), .wr_hour_i(w_hour), .wr_day_i(w_day),
    .wr_mon_i(w_mon), .wr_year_i(w_year), .wr_wday_i(w_wd),
    .busy_o(busy), .done_o(done), .err_o(err), .recov_o(recov),
    .rd_sec_o(r_sec), .rd_min_o(r_min), .rd_hour_o(r_hour), .rd_day_o(r_day),
    .rd_mon_o(r_mon), .rd_year_o(r_year), .rd_wday_o(r_wd),
    .ce_o(ce), .req_o(req), .req_we_o(req_we), .req_addr_o(req_addr),
    .req_wdata_o(req_wdata), .req_done_i(req_done), .req_rdata_i(req_rdata)
  );

  int checks = 0, fails = 0, done_cnt = 0;
  logic [3:0] mem [16];
  int busy_left = 0;
  bit stop_f = 0;
  logic [8:0] expq [$];
  string cur_tag = "R2";

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [51:0] mem_time();
    return {mem[13], mem[12], mem[11], mem[10], mem[9], mem[8],
            mem[5], mem[4], mem[3], mem[2], mem[1], mem[0], mem[6]};
  endfunction

  function automatic logic [51:0] out_time();
    return {r_year, r_mon, r_day, r_hour, r_min, r_sec, r_wd};
  endfunction

  // register-master model: fixed latency, compares each request to the expected list
  int lat_cnt = 0;
  bit pend = 0;
  logic [8:0] cap_req;
  initial begin
    forever begin
      @(negedge clk);
      if (req_done) req_done = 1'b0;
      if (!rst_n) continue;
      if (pend) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          if (cap_req[8]) begin
            if (cap_req[7:4] != 4'hE) mem[cap_req[7:4]] = cap_req[3:0];
          end else if (cap_req[7:4] == 4'hE) begin
            req_rdata = {1'b0, 1'b1, stop_f, busy_left > 0};
            if (busy_left > 0) busy_left--;
          end else begin
            req_rdata = mem[cap_req[7:4]];
          end
          req_done = 1'b1;
          pend = 0;
        end
      end else if (req) begin
        cap_req = {req_we, req_addr, req_wdata};
        if (expq.size() == 0) check(0, {cur_tag, " unexpected request"}, 64'(cap_req), 0);
        else check(cap_req == expq[0], {cur_tag, " request order"}, 64'(cap_req),
                   64'(expq[0]));
        if (expq.size() != 0) void'(expq.pop_front());
        pend = 1;
        lat_cnt = LAT;
      end
    end
  end

  // per-clock monitor: req implies ce, low gaps, done count
  int low_run = GAP;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (done) done_cnt++;
      if (req && !ce) check(0, "R2 req without ce", 0, 1);
      if (ce) begin
        if (low_run >= 0) check(low_run >= GAP, "R3 ce low gap", 64'(low_run), 64'(GAP));
        low_run = -1;
      end else if (low_run < 0) low_run = 1;
      else low_run++;
    end
  end

  task automatic q_probe(input int nbusy, output bit aborted);
    for (int i = 0; i <= nbusy && i <= MAXR; i++) begin
      expq.push_back({1'b1, 4'hE, 4'h4});
      expq.push_back({1'b0, 4'hE, 4'h0});
    end
    aborted = (nbusy > MAXR);
  endtask

  task automatic q_fields(input bit we, input logic [51:0] t);
    logic [3:0] adr [13] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8, 4'h9,
                             4'hA, 4'hB, 4'hC, 4'hD, 4'h6};
    logic [7:0] b [6];
    b[0] = t[11:4]; b[1] = t[19:12]; b[2] = t[27:20];
    b[3] = t[35:28]; b[4] = t[43:36]; b[5] = t[51:44];
    for (int s = 0; s < 13; s++) begin
      logic [3:0] nib;
      if (s == 12) nib = t[3:0];
      else nib = s[0] ? b[s / 2][7:4] : b[s / 2][3:0];
      expq.push_back({we, adr[s], we ? nib : 4'h0});
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      if (!busy) check(0, {tag, " busy low during command"}, 0, 1);
      n++;
      if (n > 40000) begin
        check(0, {tag, " command never finished"}, 0, 1);
        return;
      end
    end
    check(!busy, "R7 busy low in done cycle", 64'(busy), 0);
    @(negedge clk);
    check(!done, "R7 done is one cycle", 64'(done), 0);
    check(!ce, "R7 ce low at end", 64'(ce), 0);
    check(expq.size() == 0, {tag, " all expected requests issued"}, 64'(expq.size()), 0);
  endtask

  task automatic pulse(input bit rd, input bit wr, input bit ck);
    @(negedge clk);
    st_rd = rd; st_wr = wr; st_ck = ck;
    @(negedge clk);
    st_rd = 0; st_wr = 0; st_ck = 0;
  endtask

  task automatic set_wr(input logic [51:0] t);
    {w_year, w_mon, w_day, w_hour, w_min, w_sec, w_wd} = t;
  endtask

  task automatic do_read(input int nbusy, input string tag);
    bit ab;
    logic [51:0] prev, expt;
    prev = out_time();
    expt = mem_time();
    cur_tag = tag;
    busy_left = nbusy;
    q_probe(nbusy, ab);
    if (!ab) q_fields(0, expt);
    pulse(1, 0, 0);
    wait_done(tag);
    check(err == ab, {tag, " error flag"}, 64'(err), 64'(ab));
    check(out_time() == (ab ? prev : expt), {tag, " read result"}, 64'(out_time()),
          64'(ab ? prev : expt));
  endtask

  initial begin
    logic [51:0] t1, t2;
    bit ab;
    for (int i = 0; i < 16; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    check({ce, req, busy, done, err, recov} == 6'b0, "R1 reset state",
          64'({ce, req, busy, done, err, recov}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({ce, req, busy, done, err, recov} == 6'b0, "R1 after release",
          64'({ce, req, busy, done, err, recov}), 0);

    // R5 plain read
    mem[0] = 9; mem[1] = 5; mem[2] = 7; mem[3] = 4; mem[4] = 3; mem[5] = 2; mem[6] = 6;
    mem[8] = 1; mem[9] = 3; mem[10] = 2; mem[11] = 1; mem[12] = 9; mem[13] = 9;
    do_read(0, "R5");
    check(out_time() == {8'h99, 8'h12, 8'h31, 8'h23, 8'h47, 8'h59, 4'h6}, "R5 byte packing",
          64'(out_time()), 64'({8'h99, 8'h12, 8'h31, 8'h23, 8'h47, 8'h59, 4'h6}));

    // R6 write with two busy retries (R3); inputs change after acceptance
    t1 = {8'h24, 8'h07, 8'h15, 8'h12, 8'h34, 8'h56, 4'h3};
    cur_tag = "R6";
    busy_left = 2;
    q_probe(2, ab);
    q_fields(1, t1);
    set_wr(t1);
    pulse(0, 1, 0);
    set_wr({8'h88, 8'h88, 8'h88, 8'h88, 8'h88, 8'h88, 4'h8});
    wait_done("R6");
    check(mem_time() == t1, "R6 stored nibbles", 64'(mem_time()), 64'(t1));

    // R4 boundary: 101 busy probes still succeed, 102 abort
    do_read(101, "R4 at limit");
    do_read(102, "R4 over limit");
    check(done_cnt == 4, "R7 done count", 64'(done_cnt), 4);

    // R11 priority: read wins, err clears
    cur_tag = "R11";
    busy_left = 0;
    q_probe(0, ab);
    q_fields(0, mem_time());
    pulse(1, 1, 1);
    wait_done("R11 priority");
    check(err == 0, "R4 err cleared by next command", 64'(err), 0);

    // R11 commands during busy are ignored
    t2 = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 4'h1};
    cur_tag = "R11";
    q_probe(0, ab);
    q_fields(1, t2);
    set_wr(t2);
    pulse(0, 1, 0);
    repeat (20) @(negedge clk);
    pulse(1, 0, 1);
    wait_done("R11 ignore");
    repeat (300) @(negedge clk);
    check(done_cnt == 6 && !busy, "R11 no extra command", 64'(done_cnt), 6);
    check(mem_time() == t2, "R11 write intact", 64'(mem_time()), 64'(t2));

    // R8 check without stop flag
    cur_tag = "R8";
    stop_f = 0;
    busy_left = 0;
    expq.push_back({1'b0, 4'hE, 4'h0});
    pulse(0, 0, 1);
    wait_done("R8");
    check(recov == 0, "R8 recov unchanged", 64'(recov), 0);

    // R9 check with stop flag, short poll (one busy consumed by first read)
    cur_tag = "R9";
    stop_f = 1;
    busy_left = 4;
    expq.push_back({1'b0, 4'hE, 4'h0});
    expq.push_back({1'b1, 4'h7, 4'h0});
    expq.push_back({1'b1, 4'hE, 4'h7});
    for (int i = 0; i < 4; i++) expq.push_back({1'b0, 4'hE, 4'h0});
    q_probe(0, ab);
    q_fields(1, {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'h0});
    pulse(0, 0, 1);
    wait_done("R9");
    check(recov == 1, "R10 recov set", 64'(recov), 1);
    stop_f = 0;
    do_read(0, "R9 default readback");
    check(out_time() == {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'h0}, "R9 default date",
          64'(out_time()), 64'({8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'h0}));
    check(recov == 1, "R10 recov sticky", 64'(recov), 1);

    @(negedge clk); rclr = 1;
    @(negedge clk); rclr = 0;
    check(recov == 0, "R10 recov cleared", 64'(recov), 0);

    // R9 poll limit: 105 busy after first read, 100 polls, then 5 busy probes
    cur_tag = "R9";
    stop_f = 1;
    busy_left = 106;
    expq.push_back({1'b0, 4'hE, 4'h0});
    expq.push_back({1'b1, 4'h7, 4'h0});
    expq.push_back({1'b1, 4'hE, 4'h7});
    for (int i = 0; i < PMAX; i++) expq.push_back({1'b0, 4'hE, 4'h0});
    q_probe(5, ab);
    q_fields(1, {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'h0});
    pulse(0, 0, 1);
    wait_done("R9 poll limit");
    check(err == 0 && recov == 1, "R9 poll limit result", 64'({err, recov}), 64'(2'b01));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R7 act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule